// File: doc/BRIEF.md
# Packed Palette Expander and Pixel Converter

This block holds a 256-entry colour palette for a display pipeline. Software-side logic writes it one 32-bit word at a time. Each word carries two 16-bit colour entries. On every accepted word write, both entries are unpacked and each 5-bit channel is widened to 8 bits. The result is converted to the output pixel format that is currently selected and stored in a converted table. A pixel path then presents 8-bit indices and receives ready-to-use pixels one cycle later.

The raw words are kept as written and can be read back. A change on the format input starts a background sweep that rebuilds the whole converted table from the raw words, two entries per cycle. During that sweep `busy` is high and both the write port and the lookup port hold their ready low. Right after reset, a similar sweep clears every raw word and every converted entry to zero.

Back-pressure rules: a write is taken on a cycle where `wr_valid` and `wr_ready` are both high, and a lookup is taken when `lk_valid` and `lk_ready` are both high. Both ready outputs equal `!busy`. The result side does not accept back-pressure. `res_valid` pulses for one cycle, one cycle after each accepted lookup, and `res_data` holds its value until the next accepted lookup.

Top module: `pal_xlate`

## Requirements
- R1: After reset is released, `busy` stays high for exactly 128 cycles with `wr_ready` and `lk_ready` low. Afterwards every raw word reads 0 and every entry looks up as 0.
- R2: Writing word n stores its bits [15:0] as entry 2n and its bits [31:16] as entry 2n+1.
- R3: Within each 16-bit half, red is bits [4:0], green is bits [9:5] and blue is bits [14:10]. Each channel is widened to 8 bits by appending three zero bits. Bit 15 has no effect on the converted pixel.
- R4: Format code 0 (8-bit) gives red[7:5] in bits [7:5], green[7:5] in bits [4:2] and blue[7:6] in bits [1:0], with all upper bits zero.
- R5: Format code 1 (15-bit) gives red[7:3] in bits [14:10], green[7:3] in bits [9:5] and blue[7:3] in bits [4:0], with all upper bits zero.
- R6: Format code 2 (16-bit) gives red[7:3] in bits [15:11], green[7:2] in bits [10:5] and blue[7:3] in bits [4:0], with all upper bits zero.
- R7: Format code 3 (32-bit) gives red in bits [23:16], green in bits [15:8] and blue in bits [7:0], with bits [31:24] zero.
- R8: `lk_ready` equals `!busy`. An accepted lookup raises `res_valid` on the next cycle, with `res_data` set to the converted entry. In every other cycle `res_valid` is low.
- R9: When a write and a lookup touch the same entry in the same cycle, the lookup returns the value held before the write.
- R10: When the format input differs from the format in use while idle, `busy` rises on the next cycle and stays high for 128 cycles. Afterwards every entry is converted in the new format. A format change made during a sweep is picked up by a further sweep.
- R11: `wr_ready` equals `!busy`. A write offered while `wr_ready` is low leaves both the raw word and the converted entries unchanged.
- R12: `raw_rd_data` returns, one cycle after `raw_rd_addr` is presented, the full 32-bit word last written there, including both bit 15 and bit 31.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fmt_sel | input | 2 | Output pixel format code (0: 8-bit, 1: 15-bit, 2: 16-bit, 3: 32-bit) |
| busy | output | 1 | High while the clear or re-conversion sweep runs |
| wr_valid | input | 1 | Word write offered |
| wr_ready | output | 1 | Word write can be taken |
| wr_addr | input | 7 | Word address |
| wr_data | input | 32 | Packed pair of colour entries |
| raw_rd_addr | input | 7 | Raw word readback address |
| raw_rd_data | output | 32 | Raw word readback data, one cycle later |
| lk_valid | input | 1 | Lookup offered |
| lk_ready | output | 1 | Lookup can be taken |
| lk_index | input | 8 | Palette entry index |
| res_valid | output | 1 | Lookup result valid |
| res_data | output | 32 | Converted pixel |

## Verification
The bench targets four cases.
- It sets bit 15 and bit 31 in written words. A converter that leaked the intensity bit would then show a changed pixel, and a readback path that masked it would show a changed word.
- It issues a lookup in the same cycle as a write to the same entry. A table with write-through would return the new pixel instead of the old one.
- It changes the format and then re-reads all 256 entries. A sweep that skipped an odd entry, stopped one word short, or converted with the stale format would leave mismatches. It also counts the busy cycles.
- It offers writes and lookups during a sweep. A design that ignored its own ready would corrupt a raw word or produce a stray `res_valid`.

// File: rtl/pal_pkg.sv
package pal_pkg;
  localparam int CH_W    = 5;
  localparam int EXP_W   = 8;
  localparam int HALF_W  = 16;
  localparam int WORD_W  = 2 * HALF_W;
  localparam int PIX_W   = 32;

  typedef enum logic [1:0] {
    PF_RGB332   = 2'd0,
    PF_RGB555   = 2'd1,
    PF_RGB565   = 2'd2,
    PF_XRGB8888 = 2'd3
  } pix_fmt_e;

  typedef struct packed {
    logic [EXP_W-1:0] r;
    logic [EXP_W-1:0] g;
    logic [EXP_W-1:0] b;
  } rgb_t;
endpackage

// File: rtl/pal_conv.sv
module pal_conv
  import pal_pkg::*;
(
  input  logic [HALF_W-1:0] half_in,
  input  pix_fmt_e          fmt,
  output logic [PIX_W-1:0]  pix
);
  localparam int PAD = EXP_W - CH_W;
  rgb_t c;

  // widen each 5-bit field; bit 15 (intensity) is dropped
  always_comb begin
    c.r = {half_in[CH_W-1:0],          {PAD{1'b0}}};
    c.g = {half_in[2*CH_W-1:CH_W],     {PAD{1'b0}}};
    c.b = {half_in[3*CH_W-1:2*CH_W],   {PAD{1'b0}}};
  end

  always_comb begin
    pix = '0;
    unique case (fmt)
      PF_RGB332:   pix[7:0]  = {c.r[7:5], c.g[7:5], c.b[7:6]};
      PF_RGB555:   pix[14:0] = {c.r[7:3], c.g[7:3], c.b[7:3]};
      PF_RGB565:   pix[15:0] = {c.r[7:3], c.g[7:2], c.b[7:3]};
      PF_XRGB8888: pix[23:0] = {c.r, c.g, c.b};
      default:     pix = '0;
    endcase
  end
endmodule

// File: rtl/pal_sweep.sv
module pal_sweep
  import pal_pkg::*;
#(
  parameter int WORDS = 128,
  localparam int IW = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  pix_fmt_e      fmt_req,
  output pix_fmt_e      cur_fmt,
  output logic          busy,
  output logic          init_phase,
  output logic [IW-1:0] word_idx
);
  typedef enum logic [1:0] {S_INIT, S_IDLE, S_SCAN} st_e;
  st_e st;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_INIT;
      word_idx <= '0;
      cur_fmt  <= PF_RGB332;
    end else begin
      unique case (st)
        S_IDLE: begin
          if (fmt_req != cur_fmt) begin
            cur_fmt  <= fmt_req;
            st       <= S_SCAN;
            word_idx <= '0;
          end
        end
        S_INIT, S_SCAN: begin
          if (word_idx == IW'(WORDS - 1)) st <= S_IDLE;
          word_idx <= word_idx + 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy       = (st != S_IDLE);
  assign init_phase = (st == S_INIT);
endmodule

// File: rtl/pal_xlate.sv
module pal_xlate
  import pal_pkg::*;
#(
  parameter int ENTRIES = 256,
  localparam int WORDS = ENTRIES / 2,
  localparam int WA_W  = $clog2(WORDS),
  localparam int IX_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        fmt_sel,
  output logic              busy,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [WA_W-1:0]   wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [WA_W-1:0]   raw_rd_addr,
  output logic [WORD_W-1:0] raw_rd_data,
  input  logic              lk_valid,
  output logic              lk_ready,
  input  logic [IX_W-1:0]   lk_index,
  output logic              res_valid,
  output logic [PIX_W-1:0]  res_data
);
  logic [WORD_W-1:0] raw_mem  [WORDS];
  logic [PIX_W-1:0]  conv_mem [ENTRIES];

  pix_fmt_e        cur_fmt;
  logic            init_phase;
  logic [WA_W-1:0] sweep_idx;

  pal_sweep #(.WORDS(WORDS)) u_sweep (
    .clk        (clk),
    .rst_n      (rst_n),
    .fmt_req    (pix_fmt_e'(fmt_sel)),
    .cur_fmt    (cur_fmt),
    .busy       (busy),
    .init_phase (init_phase),
    .word_idx   (sweep_idx)
  );

  assign wr_ready = !busy;
  assign lk_ready = !busy;

  logic wr_fire, lk_fire;
  assign wr_fire = wr_valid && wr_ready;
  assign lk_fire = lk_valid && lk_ready;

  // source word and target word address: sweep owns the table while busy
  logic [WORD_W-1:0] src_word;
  logic [WA_W-1:0]   tgt_word;
  logic              conv_we;

  always_comb begin
    if (busy) begin
      src_word = init_phase ? '0 : raw_mem[sweep_idx];
      tgt_word = sweep_idx;
      conv_we  = 1'b1;
    end else begin
      src_word = wr_data;
      tgt_word = wr_addr;
      conv_we  = wr_fire;
    end
  end

  logic [PIX_W-1:0] half_pix [2];

  for (genvar h = 0; h < 2; h++) begin : g_half
    pal_conv u_conv (
      .half_in (src_word[h*HALF_W +: HALF_W]),
      .fmt     (cur_fmt),
      .pix     (half_pix[h])
    );
  end

  always_ff @(posedge clk) begin
    if (busy && init_phase)      raw_mem[sweep_idx] <= '0;
    else if (wr_fire)            raw_mem[wr_addr]   <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (conv_we) begin
      conv_mem[{tgt_word, 1'b0}] <= half_pix[0];
      conv_mem[{tgt_word, 1'b1}] <= half_pix[1];
    end
  end

  always_ff @(posedge clk) begin
    raw_rd_data <= raw_mem[raw_rd_addr];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_data  <= '0;
    end else begin
      res_valid <= lk_fire;
      if (lk_fire) res_data <= conv_mem[lk_index];
    end
  end
endmodule

// File: rtl/pal_xlate_chk.sv
module pal_xlate_chk #(
  parameter int WORDS = 128
) (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] fmt_sel,
  input logic [1:0] cur_fmt,
  input logic       busy,
  input logic       wr_ready,
  input logic       lk_valid,
  input logic       lk_ready,
  input logic       res_valid
);
  logic [$clog2(WORDS+2)-1:0] busy_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)    busy_cnt <= '0;
    else if (busy) busy_cnt <= busy_cnt + 1'b1;
    else           busy_cnt <= '0;
  end

  // R8 / R11: both ready outputs drop during any sweep
  assert_ready_gated_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (!lk_ready && !wr_ready));

  // R8: a pulse of res_valid follows each accepted lookup
  assert_result_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && lk_ready) |=> res_valid);

  assert_no_stray_result_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(lk_valid && lk_ready) |=> !res_valid);

  // R10: a new format while idle starts a sweep
  assert_fmt_starts_sweep_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && fmt_sel != cur_fmt) |=> busy);

  // R1 / R10: every sweep lasts exactly WORDS cycles
  assert_sweep_length_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_cnt == WORDS));
endmodule

bind pal_xlate pal_xlate_chk #(.WORDS(WORDS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .fmt_sel   (fmt_sel),
  .cur_fmt   (cur_fmt),
  .busy      (busy),
  .wr_ready  (wr_ready),
  .lk_valid  (lk_valid),
  .lk_ready  (lk_ready),
  .res_valid (res_valid)
);

// File: tb/pal_xlate_bench.sv
`timescale 1ns/1ps
module pal_xlate_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  fmt_sel = 2'd0;
  logic        busy, wr_ready, lk_ready, res_valid;
  logic        wr_valid = 1'b0;
  logic [6:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [6:0]  raw_rd_addr = '0;
  logic [31:0] raw_rd_data;
  logic        lk_valid = 1'b0;
  logic [7:0]  lk_index = '0;
  logic [31:0] res_data;

  always #2.5 clk = ~clk;

  pal_xlate u_pal_xlate (
    .clk(clk), .rst_n(rst_n), .fmt_sel(fmt_sel), .busy(busy),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .raw_rd_addr(raw_rd_addr), .raw_rd_data(raw_rd_data),
    .lk_valid(lk_valid), .lk_ready(lk_ready), .lk_index(lk_index),
    .res_valid(res_valid), .res_data(res_data)
  );

  int checks = 0;
  int errors = 0;
  logic [31:0] model [128];
  logic [1:0]  mfmt = 2'd0;

  function automatic logic [31:0] expect_pix(logic [15:0] h, logic [1:0] f);
    logic [7:0] r, g, b;
    r = {3'b0, h[4:0]}   << 3;
    g = {3'b0, h[9:5]}   << 3;
    b = {3'b0, h[14:10]} << 3;
    case (f)
      2'd0:    return {24'd0, r[7:5], g[7:5], b[7:6]};
      2'd1:    return {17'd0, r[7:3], g[7:3], b[7:3]};
      2'd2:    return {16'd0, r[7:3], g[7:2], b[7:3]};
      default: return {8'd0, r, g, b};
    endcase
  endfunction

  function automatic logic [31:0] expect_entry(int idx);
    logic [31:0] w;
    w = model[idx >> 1];
    return expect_pix((idx & 1) ? w[31:16] : w[15:0], mfmt);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_write(logic [6:0] a, logic [31:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
    model[a] = d;
  endtask

  task automatic do_lookup(logic [7:0] i, output logic [31:0] v, output logic vld);
    @(negedge clk);
    lk_valid = 1'b1; lk_index = i;
    @(negedge clk);
    lk_valid = 1'b0;
    v = res_data; vld = res_valid;
  endtask

  task automatic do_read(logic [6:0] a, output logic [31:0] v);
    @(negedge clk);
    raw_rd_addr = a;
    @(negedge clk);
    v = raw_rd_data;
  endtask

  task automatic check_all(string req);
    logic [31:0] v; logic vld;
    for (int i = 0; i < 256; i++) begin
      do_lookup(8'(i), v, vld);
      chk(req, {31'd0, vld}, 32'd1);
      chk(req, v, expect_entry(i));
    end
  endtask

  task automatic count_busy(output int n);
    n = 0;
    while (busy && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic set_fmt(logic [1:0] f, string req);
    int n;
    @(negedge clk);
    fmt_sel = f; mfmt = f;
    @(negedge clk);
    chk(req, {31'd0, busy}, 32'd1);
    count_busy(n);
    chk(req, 32'(n), 32'd128);
  endtask

  initial begin
    #400000;
    errors++; checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v, v2; logic vld; int n;
    void'($urandom(32'd2024));
    for (int i = 0; i < 128; i++) model[i] = '0;

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1: clear sweep after reset
    chk("R1 busy", {31'd0, busy}, 32'd1);
    chk("R1 rdy", {30'd0, wr_ready, lk_ready}, 32'd0);
    count_busy(n);
    chk("R1 len", 32'(n), 32'd128);
    do_read(7'd77, v);
    chk("R1 raw", v, 32'd0);
    check_all("R1 entries");

    // R2 R3 R4: directed halves in 8-bit format
    do_write(7'd3, 32'h001F_7C00);
    do_lookup(8'd6, v, vld);
    chk("R2 lo", v, expect_pix(16'h7C00, 2'd0));
    chk("R4 blue", v, 32'h0000_0003);
    do_lookup(8'd7, v, vld);
    chk("R2 hi", v, 32'h0000_00E0);
    // R3: intensity bit ignored, readback keeps it (R12)
    do_write(7'd9, 32'h83E0_03E0);
    do_lookup(8'd18, v, vld);
    do_lookup(8'd19, v2, vld);
    chk("R3 ibit", v, v2);
    chk("R3 green", v, 32'h0000_001C);
    do_read(7'd9, v);
    chk("R12 raw", v, 32'h83E0_03E0);

    // R9: write and lookup same entry same cycle
    do_write(7'd20, 32'h0000_001F);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = 7'd20; wr_data = 32'h0000_7C00;
    lk_valid = 1'b1; lk_index = 8'd40;
    @(negedge clk);
    wr_valid = 1'b0; lk_valid = 1'b0;
    chk("R9 old", res_data, expect_pix(16'h001F, 2'd0));
    model[20] = 32'h0000_7C00;
    do_lookup(8'd40, v, vld);
    chk("R9 new", v, expect_entry(40));

    // random writes in 8-bit format
    for (int k = 0; k < 60; k++) do_write(7'($urandom), $urandom);
    for (int k = 0; k < 40; k++) begin
      logic [7:0] ix = 8'($urandom);
      do_lookup(ix, v, vld);
      chk("R4 rand", v, expect_entry(ix));
    end
    for (int k = 0; k < 20; k++) begin
      logic [6:0] a = 7'($urandom);
      do_read(a, v);
      chk("R12 rand", v, model[a]);
    end

    // R5 R6 R7 R10: reconvert in each format
    set_fmt(2'd1, "R10 to15");
    check_all("R5");
    set_fmt(2'd2, "R10 to16");
    check_all("R6");
    set_fmt(2'd3, "R10 to32");
    do_lookup(8'd7, v, vld);
    chk("R7 red", v, expect_entry(7));
    check_all("R7");

    // R11 R8: port activity during a sweep has no effect
    @(negedge clk);
    fmt_sel = 2'd1; mfmt = 2'd1;
    @(negedge clk);
    chk("R8 rdy", {31'd0, lk_ready}, 32'd0);
    wr_valid = 1'b1; wr_addr = 7'd5; wr_data = 32'hFFFF_FFFF;
    lk_valid = 1'b1; lk_index = 8'd3;
    @(negedge clk);
    chk("R8 stray", {31'd0, res_valid}, 32'd0);
    // R10: change again mid-sweep
    fmt_sel = 2'd2; mfmt = 2'd2;
    wr_valid = 1'b0; lk_valid = 1'b0;
    n = 0;
    while (n < 400 && (busy || n < 140)) begin n++; @(negedge clk); end
    chk("R10 idle", {31'd0, busy}, 32'd0);
    do_read(7'd5, v);
    chk("R11 raw", v, model[5]);
    check_all("R10 mid");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule